// File: doc/BRIEF.md
# Capacitor Stage Toggle Guard

This block watches the switch command of the smallest shunt capacitor stage of a stepped reactive compensator. It looks for the stage being switched in and out over and over, a condition that makes the bus voltage flicker. When it finds that pattern, it widens the regulator's upper dead band for a fixed hold time. The wider band lets the stage stay switched in, and the loop settles.

The block keeps a copy of the stage enable and refreshes it every 100 ms of a millisecond tick. At each refresh it compares the live enable with the held copy. Each mismatch counts as one change. A free-running 2 s window opens with a 20 ms clear pulse, which resets an 8-bit change counter. When the counter reaches six inside one window, a retriggerable 6 s hold timer starts. While the timer runs, a boost of 20 percentage points is added to the configured upper bandwidth. The result is always limited to at most +10 %. The effective bandwidth feeds the voltage regulator's dead-band comparator.

Top module: `toggle_guard`

## Requirements
- R1: After reset, no boost is active and `eff_upper_bw` equals the configured bandwidth clamped to at most +10.
- R2: Only `stage1_en` is observed. A held copy of it is refreshed on every 100th `ms_tick`, starting from reset. At each refresh where the live enable differs from the held copy, exactly one change is counted.
- R3: A free-running window of 2000 ticks restarts at reset. Its first 20 ticks form a clear pulse. The change counter reads zero throughout the pulse, and changes found during the pulse are discarded.
- R4: When the count reaches six inside one window, a hold of 6000 ticks starts.
- R5: A new trigger while the hold runs reloads the full 6000 ticks.
- R6: While the hold runs, `eff_upper_bw` equals `cfg_upper_bw + 20`, limited to at most +10. Values are two's-complement signed whole percent.
- R7: When the hold reaches zero, the output returns to the clamped configured value in the same clock that ends the hold.
- R8: Toggling slow enough that fewer than six changes are counted in any window never produces a boost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-clock pulse per millisecond |
| stage1_en | input | 1 | Switch command of the smallest capacitor stage |
| cfg_upper_bw | input | 8 | Configured upper bandwidth, signed percent |
| eff_upper_bw | output | 8 | Effective upper bandwidth, signed percent |

## Verification
The assertions assume that `ms_tick` lasts at most one clock per pulse. They also assume that `stage1_en` and `cfg_upper_bw` are synchronous to `clk`. The stimulus therefore drives every input a fixed delay after the rising edge and raises the tick on every second clock. The configured bandwidth stays between -20 and +12, so the boosted sum lies well inside the 9-bit internal range. Toggle periods of 150 ms and 500 ms land on either side of the six-change threshold. The comparison against a per-clock model covers the exact trigger, retrigger and expiry cycles.

// File: rtl/tg_pkg.sv
package tg_pkg;
    // Defaults shared by the guard and its submodules
    localparam int TG_BW_W      = 8;
    localparam int TG_CNT_W     = 8;
    localparam int TG_SAMPLE_MS = 100;
    localparam int TG_WINDOW_MS = 2000;
    localparam int TG_PULSE_MS  = 20;
    localparam int TG_HOLD_MS   = 6000;
    localparam int TG_TRIG_CNT  = 6;
    localparam int TG_BOOST     = 20;
    localparam int TG_BW_MAX    = 10;
endpackage

// File: rtl/tg_sampler.sv
module tg_sampler #(
    parameter int SAMPLE_MS = tg_pkg::TG_SAMPLE_MS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic en_i,
    output logic evt_o
);
    localparam int SW = (SAMPLE_MS > 1) ? $clog2(SAMPLE_MS) : 1;

    typedef struct packed {
        logic [SW-1:0] div;
        logic          held;
    } samp_t;

    samp_t s_d, s_q;
    logic  refresh;

    always_comb begin
        s_d     = s_q;
        refresh = ms_tick && (s_q.div == SW'(SAMPLE_MS - 1));
        evt_o   = refresh && (en_i ^ s_q.held);
        if (ms_tick) begin
            s_d.div = refresh ? '0 : s_q.div + 1'b1;
        end
        if (refresh) begin
            s_d.held = en_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tg_window.sv
module tg_window #(
    parameter int WINDOW_MS = tg_pkg::TG_WINDOW_MS,
    parameter int PULSE_MS  = tg_pkg::TG_PULSE_MS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    output logic pulse_o
);
    localparam int WW = (WINDOW_MS > 1) ? $clog2(WINDOW_MS) : 1;

    logic [WW-1:0] ph_d, ph_q;

    always_comb begin
        ph_d    = ph_q;
        pulse_o = (ph_q < WW'(PULSE_MS));
        if (ms_tick) begin
            ph_d = (ph_q == WW'(WINDOW_MS - 1)) ? '0 : ph_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end
endmodule

// File: rtl/tg_counter.sv
module tg_counter #(
    parameter int CNT_W     = tg_pkg::TG_CNT_W,
    parameter int TRIG_CNT  = tg_pkg::TG_TRIG_CNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             evt_i,
    output logic             trig_o,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        trig_o = 1'b0;
        if (clr_i) begin
            // events inside the clear pulse are discarded
            cnt_d = '0;
        end else if (evt_i) begin
            cnt_d  = cnt_q + 1'b1;   // wraps from all-ones to zero
            trig_o = (cnt_q == CNT_W'(TRIG_CNT - 1));
        end
        cnt_o = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tg_hold.sv
module tg_hold #(
    parameter int HOLD_MS = tg_pkg::TG_HOLD_MS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic trig_i,
    output logic active_o
);
    localparam int HW = $clog2(HOLD_MS + 1);

    logic [HW-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (trig_i) begin
            rem_d = HW'(HOLD_MS);      // full reload, also while running
        end else if (ms_tick && (rem_q != '0)) begin
            rem_d = rem_q - 1'b1;
        end
        active_o = (rem_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end
endmodule

// File: rtl/toggle_guard.sv
module toggle_guard #(
    parameter int BW_W      = tg_pkg::TG_BW_W,
    parameter int CNT_W     = tg_pkg::TG_CNT_W,
    parameter int SAMPLE_MS = tg_pkg::TG_SAMPLE_MS,
    parameter int WINDOW_MS = tg_pkg::TG_WINDOW_MS,
    parameter int PULSE_MS  = tg_pkg::TG_PULSE_MS,
    parameter int HOLD_MS   = tg_pkg::TG_HOLD_MS,
    parameter int TRIG_CNT  = tg_pkg::TG_TRIG_CNT,
    parameter int BOOST     = tg_pkg::TG_BOOST,
    parameter int BW_MAX    = tg_pkg::TG_BW_MAX
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ms_tick,
    input  logic                   stage1_en,
    input  logic signed [BW_W-1:0] cfg_upper_bw,
    output logic signed [BW_W-1:0] eff_upper_bw
);
    localparam int SW = BW_W + 1;
    localparam logic signed [SW-1:0] MAX_S   = SW'(BW_MAX);
    localparam logic signed [SW-1:0] BOOST_S = SW'(BOOST);

    logic             evt;
    logic             win_pulse;
    logic             trig;
    logic             boost_on;
    logic [CNT_W-1:0] cnt;
    logic signed [SW-1:0] sum;

    tg_sampler #(.SAMPLE_MS(SAMPLE_MS)) u_samp (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .en_i(stage1_en), .evt_o(evt)
    );

    tg_window #(.WINDOW_MS(WINDOW_MS), .PULSE_MS(PULSE_MS)) u_win (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pulse_o(win_pulse)
    );

    tg_counter #(.CNT_W(CNT_W), .TRIG_CNT(TRIG_CNT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(win_pulse), .evt_i(evt),
        .trig_o(trig), .cnt_o(cnt)
    );

    tg_hold #(.HOLD_MS(HOLD_MS)) u_hold (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .trig_i(trig), .active_o(boost_on)
    );

    // boosted sum, one bit wider, then clamped at the ceiling
    always_comb begin
        sum = $signed({cfg_upper_bw[BW_W-1], cfg_upper_bw})
            + (boost_on ? BOOST_S : '0);
        if (sum > MAX_S) eff_upper_bw = MAX_S[BW_W-1:0];
        else             eff_upper_bw = sum[BW_W-1:0];
    end
endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
    parameter int BW_W   = 8,
    parameter int CNT_W  = 8,
    parameter int BW_MAX = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ms_tick,
    input logic                   evt,
    input logic                   win_pulse,
    input logic                   trig,
    input logic                   boost_on,
    input logic [CNT_W-1:0]       cnt,
    input logic signed [BW_W-1:0] eff_upper_bw
);
    localparam logic signed [BW_W-1:0] MAX_V = BW_W'(BW_MAX);

    // R6
    eff_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eff_upper_bw <= MAX_V);

    // R3
    pulse_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_pulse |=> (cnt == '0));

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_pulse && !evt) |=> $stable(cnt));

    // R2
    evt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> ms_tick);

    // R4
    trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> boost_on);

    // R7
    hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ms_tick && !trig) |=> $stable(boost_on));
endmodule

bind toggle_guard tg_checker #(.BW_W(BW_W), .CNT_W(CNT_W), .BW_MAX(BW_MAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .evt(evt),
    .win_pulse(win_pulse), .trig(trig), .boost_on(boost_on),
    .cnt(cnt), .eff_upper_bw(eff_upper_bw)
);

// File: tb/toggle_guard_tb.sv
module toggle_guard_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ms_tick = 1'b0;
    logic              stage1_en = 1'b0;
    logic signed [7:0] cfg_upper_bw = 8'sd3;
    logic signed [7:0] eff_upper_bw;

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    // behavioural reference state
    int m_div, m_held, m_win, m_cnt, m_hold;

    toggle_guard u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .stage1_en(stage1_en), .cfg_upper_bw(cfg_upper_bw),
        .eff_upper_bw(eff_upper_bw)
    );

    always #10 clk = ~clk;

    function automatic int clampv(int v);
        return (v > 10) ? 10 : v;
    endfunction

    function automatic int expected();
        return clampv(int'(cfg_upper_bw) + ((m_hold > 0) ? 20 : 0));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_held = 0; m_win = 0; m_cnt = 0; m_hold = 0;
        end else begin
            bit pulse, refresh, ev, trg;
            pulse   = (m_win < 20);
            refresh = ms_tick && (m_div == 99);
            ev      = refresh && (int'(stage1_en) != m_held);
            trg     = ev && !pulse && (m_cnt == 5);
            if (pulse) m_cnt = 0;
            else if (ev) m_cnt = (m_cnt + 1) % 256;
            if (refresh) m_held = int'(stage1_en);
            if (ms_tick) begin
                m_div = (m_div == 99) ? 0 : m_div + 1;
                m_win = (m_win == 1999) ? 0 : m_win + 1;
            end
            if (trg) m_hold = 6000;
            else if (ms_tick && m_hold > 0) m_hold = m_hold - 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (int'(eff_upper_bw) != expected()) begin
                failures++;
                $display("FAIL %s model: eff=%0d expected %0d at %0t",
                         tag, eff_upper_bw, expected(), $time);
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_ms(int n);
        step(2 * n);
    endtask

    task automatic toggle(int period_ms, int total_ms);
        for (int t = 0; t < total_ms; t += period_ms) begin
            wait_ms(period_ms);
            stage1_en = ~stage1_en;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2;
            ms_tick = ~ms_tick;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(5);
        rst_n = 1'b1;
        step(1);
        // R1: idle output equals configured value
        chk("R1", int'(eff_upper_bw), 3);

        // R2: steady enable produces at most one change, no boost
        tag = "R2";
        stage1_en = 1'b1;
        wait_ms(4000);
        chk("R2", int'(eff_upper_bw), 3);

        // R8: 500 ms toggling stays below six changes per window
        tag = "R8";
        toggle(500, 6000);
        chk("R8", int'(eff_upper_bw), 3);

        // R4 / R6: fast toggling triggers, boost saturates at 10
        tag = "R4";
        toggle(150, 3000);
        chk("R4", int'(eff_upper_bw), 10);
        tag = "R6";
        cfg_upper_bw = -8'sd15;
        step(1);
        chk("R6", int'(eff_upper_bw), 5);

        // R5: continued toggling keeps retriggering the hold
        tag = "R5";
        toggle(150, 6000);
        chk("R5", int'(eff_upper_bw), 5);

        // R7: stop toggling, hold expires, output returns to config
        tag = "R7";
        wait_ms(7000);
        chk("R7", int'(eff_upper_bw), -15);

        // R3: toggling confined near window start, model covers pulse drop
        tag = "R3";
        toggle(150, 1500);
        wait_ms(7000);
        chk("R3", int'(eff_upper_bw), -15);

        // R6: configured value above ceiling is clamped with no boost
        tag = "R6";
        cfg_upper_bw = 8'sd12;
        step(1);
        chk("R6", int'(eff_upper_bw), 10);

        // R1: reset again mid-run clears boost state
        tag = "R1";
        cfg_upper_bw = 8'sd2;
        toggle(150, 3000);
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
        chk("R1", int'(eff_upper_bw), 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule